// File: doc/BRIEF.md
# Standby Mode Clock Controller

This block produces the clock enables for a small 4-bit microcontroller core that has two low-power modes. All of its logic runs on one free-running reference clock, which stands in for the oscillator. It drives an oscillator-run flag and a system-clock enable. It also drives a CPU-clock enable that fires on every second system-clock enable. The core drives three one-cycle strobes into it: enter-stop, enter-halt and leave-halt. The board drives one more input, an asynchronous active-high RESET pin.

Two standby flops sit at the centre of the block, and each has its own way out. Stop mode shuts the oscillator and every clock. Only RESET ends it. Halt mode freezes the divide-by-two stage, so the CPU clock stops while the system clock keeps running. A leave-halt strobe ends halt mode, and so does the falling edge of RESET. While RESET is high, halt mode is forced on. This keeps the CPU clock quiet until the oscillator has settled, so the RESET pulse has to be longer than the oscillator start-up time.

Top module: `stby_clk_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the outputs read stop_mode=0, halt_mode=1, osc_run=1, sys_clk_en=1 and cpu_clk_en=0. The RESET synchroniser also holds a value of 1 during `rst`.
- R2: The `reset_pin` input passes through SYNC_STAGES synchroniser flops, with a default of 2. A level change on the pin reaches the mode flops SYNC_STAGES+1 rising edges after the pin is sampled.
- R3: When synchronised RESET is low, a high `stop_req` sets stop_mode at the next edge. One edge later, osc_run, sys_clk_en and cpu_clk_en are all 0.
- R4: Once stop_mode is set, it stays set until synchronised RESET is high. `halt_req` and `halt_release` have no effect on it. The first edge with synchronised RESET high clears it, and osc_run returns one edge after that.
- R5: A high `halt_req` sets halt_mode. While halt_mode is 1 and stop_mode is 0, sys_clk_en stays 1 and cpu_clk_en stays 0.
- R6: A high `halt_release` clears halt_mode. If `halt_req` and `halt_release` are high in the same cycle, halt_mode ends up set.
- R7: The first cycle in which synchronised RESET is low after being high is its falling edge. At that edge halt_mode clears, even if `halt_req` is high in the same cycle.
- R8: While synchronised RESET is high, halt_mode is forced to 1 and stop_mode to 0, whatever the strobes do.
- R9: When neither mode is set, cpu_clk_en is high on alternate cycles. Over any even run of running cycles it is high exactly half as often as sys_clk_en, and it is never high in two cycles in a row.
- R10: The divider phase is held while either mode is set. After halt ends, the CPU-enable pattern continues from the phase it had when halt began.
- R11: cpu_clk_en is 0 from the second edge after synchronised RESET rises until one edge after halt_mode clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high block reset |
| reset_pin | input | 1 | Asynchronous active-high RESET from the board |
| stop_req | input | 1 | One-cycle strobe to enter stop mode |
| halt_req | input | 1 | One-cycle strobe to enter halt mode |
| halt_release | input | 1 | Request to leave halt mode |
| osc_run | output | 1 | High while the oscillator is allowed to run |
| sys_clk_en | output | 1 | System-clock enable |
| cpu_clk_en | output | 1 | CPU-clock enable, half the system rate |
| stop_mode | output | 1 | Stop flop state |
| halt_mode | output | 1 | Halt flop state |

## Verification
A bad mode flop shows on stop_mode or halt_mode at the very next edge. One edge later it also shows on the enables: sys_clk_en and osc_run drop, or cpu_clk_en pulses when it should be quiet. A bad divider phase does not show as a change in the pulse rate. It shows as a CPU pulse landing one cycle early or late, seen at the first enable after a halt or a reset. The bench therefore checks every output against a behavioural model on every cycle, so any such slip is caught within one or two cycles of its cause.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef struct packed {
    logic stop;
    logic halt;
  } mode_t;

  localparam mode_t MODE_POR = '{stop: 1'b0, halt: 1'b1};
endpackage

// File: rtl/stby_rst_sync.sv
module stby_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rst_s,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain[LAST];
  end

  assign rst_s = chain[LAST];
  assign fall  = prev_q & ~chain[LAST];

  // R7: the falling-edge pulse lasts exactly one cycle
  a_r7_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/stby_mode_ff.sv
module stby_mode_ff
  import stby_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rst_s,
  input  logic  fall,
  input  logic  stop_req,
  input  logic  halt_req,
  input  logic  halt_release,
  output mode_t mode
);
  mode_t mode_d;

  always_comb begin
    mode_d = mode;
    if (rst_s) begin
      mode_d.stop = 1'b0;
      mode_d.halt = 1'b1;
    end else begin
      if (stop_req) mode_d.stop = 1'b1;
      if (fall)              mode_d.halt = 1'b0;
      else if (halt_req)     mode_d.halt = 1'b1;
      else if (halt_release) mode_d.halt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_POR;
    else     mode <= mode_d;
  end

  // R8: synchronised RESET forces halt on and stop off
  a_r8_reset_forces: assert property (@(posedge clk) disable iff (rst)
    rst_s |=> (mode.halt && !mode.stop));
  // R4: stop is sticky until RESET
  a_r4_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode.stop && !rst_s) |=> mode.stop);
  // R6: a halt strobe beats a release in the same cycle
  a_r6_halt_wins: assert property (@(posedge clk) disable iff (rst)
    (!rst_s && !fall && halt_req) |=> mode.halt);
  // R7: the RESET fall clears halt
  a_r7_fall_clears: assert property (@(posedge clk) disable iff (rst)
    fall |=> !mode.halt);
endmodule

// File: rtl/stby_half_div.sv
module stby_half_div
  import stby_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  output logic  osc_run,
  output logic  sys_en,
  output logic  cpu_en
);
  logic phase_q;
  logic running;

  assign running = !mode.stop && !mode.halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      osc_run <= 1'b1;
      sys_en  <= 1'b1;
      cpu_en  <= 1'b0;
    end else begin
      if (running) phase_q <= ~phase_q;
      osc_run <= !mode.stop;
      sys_en  <= !mode.stop;
      cpu_en  <= running && phase_q;
    end
  end

  // R9: never two CPU enables back to back
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    cpu_en |=> !cpu_en);
  // R3: stop removes every enable one edge later
  a_r3_stop_gates: assert property (@(posedge clk) disable iff (rst)
    mode.stop |=> (!osc_run && !sys_en && !cpu_en));
  // R5: halt keeps system enable, removes CPU enable
  a_r5_halt_gates: assert property (@(posedge clk) disable iff (rst)
    (mode.halt && !mode.stop) |=> (sys_en && !cpu_en));
endmodule

// File: rtl/stby_clk_ctrl.sv
module stby_clk_ctrl
  import stby_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic reset_pin,
  input  logic stop_req,
  input  logic halt_req,
  input  logic halt_release,
  output logic osc_run,
  output logic sys_clk_en,
  output logic cpu_clk_en,
  output logic stop_mode,
  output logic halt_mode
);
  logic  rst_s;
  logic  rst_fall;
  mode_t mode;

  stby_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   (reset_pin),
    .rst_s (rst_s),
    .fall  (rst_fall)
  );

  stby_mode_ff u_mode (
    .clk          (clk),
    .rst          (rst),
    .rst_s        (rst_s),
    .fall         (rst_fall),
    .stop_req     (stop_req),
    .halt_req     (halt_req),
    .halt_release (halt_release),
    .mode         (mode)
  );

  stby_half_div u_div (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .osc_run (osc_run),
    .sys_en  (sys_clk_en),
    .cpu_en  (cpu_clk_en)
  );

  assign stop_mode = mode.stop;
  assign halt_mode = mode.halt;

  // R11: held RESET keeps the CPU enable low
  a_r11_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    (rst_s && halt_mode) |=> !cpu_clk_en);
endmodule

// File: tb/stby_clk_ctrl_tb.sv
module stby_clk_ctrl_tb;
  localparam int SYNC = 2;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reset_pin = 1'b1;
  logic stop_req = 1'b0, halt_req = 1'b0, halt_release = 1'b0;
  logic osc_run, sys_clk_en, cpu_clk_en, stop_mode, halt_mode;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";

  always #HALF clk = ~clk;

  stby_clk_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .reset_pin(reset_pin),
    .stop_req(stop_req), .halt_req(halt_req), .halt_release(halt_release),
    .osc_run(osc_run), .sys_clk_en(sys_clk_en), .cpu_clk_en(cpu_clk_en),
    .stop_mode(stop_mode), .halt_mode(halt_mode)
  );

  // behavioural reference model
  bit pin_hist[$];
  bit m_prev = 1, m_stop = 0, m_halt = 1, m_ph = 0;
  bit m_osc = 1, m_sys = 1, m_cpu = 0;

  initial for (int i = 0; i < SYNC; i++) pin_hist.push_back(1'b1);

  always @(posedge clk) begin
    if (rst) begin
      pin_hist.delete();
      for (int i = 0; i < SYNC; i++) pin_hist.push_back(1'b1);
      m_prev = 1; m_stop = 0; m_halt = 1; m_ph = 0;
      m_osc = 1; m_sys = 1; m_cpu = 0;
    end else begin
      bit rs, fl, run, nstop, nhalt;
      rs  = pin_hist[0];
      fl  = m_prev && !rs;
      run = !m_stop && !m_halt;
      nstop = rs ? 1'b0 : (stop_req ? 1'b1 : m_stop);
      if (rs)                nhalt = 1'b1;
      else if (fl)           nhalt = 1'b0;
      else if (halt_req)     nhalt = 1'b1;
      else if (halt_release) nhalt = 1'b0;
      else                   nhalt = m_halt;
      m_cpu = run && m_ph;
      if (run) m_ph = !m_ph;
      m_osc = !m_stop;
      m_sys = !m_stop;
      m_stop = nstop;
      m_halt = nhalt;
      m_prev = rs;
      void'(pin_hist.pop_front());
      pin_hist.push_back(reset_pin);
    end
  end

  task automatic chk(string what, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare at negedge, then apply the next inputs
  task automatic cyc(bit s, bit h, bit r, bit p);
    @(negedge clk);
    chk("stop_mode", stop_mode, m_stop);
    chk("halt_mode", halt_mode, m_halt);
    chk("osc_run", osc_run, m_osc);
    chk("sys_clk_en", sys_clk_en, m_sys);
    chk("cpu_clk_en", cpu_clk_en, m_cpu);
    stop_req = s; halt_req = h; halt_release = r; reset_pin = p;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int ns, nc;
    bit [15:0] lf;
    // R1: reset state
    tag = "R1";
    repeat (3) cyc(0, 0, 0, 1);
    @(negedge clk);
    n_checks++;
    if (!(halt_mode === 1 && stop_mode === 0 && osc_run === 1 && sys_clk_en === 1 && cpu_clk_en === 0)) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual=%0b%0b%0b%0b%0b expected=01110",
               stop_mode, halt_mode, osc_run, sys_clk_en, cpu_clk_en);
    end
    rst = 1'b0;
    // R8, R11: strobes while RESET high are overridden, no CPU pulses
    tag = "R8";
    cyc(1, 1, 0, 1); cyc(0, 0, 0, 1); cyc(1, 0, 1, 1);
    tag = "R11";
    ns = 0;
    for (int i = 0; i < 10; i++) begin cyc(0, 0, 0, 1); ns += cpu_clk_en; end
    n_checks++;
    if (ns != 0) begin n_fail++; $display("FAIL R11 cpu pulses in reset actual=%0d expected=0", ns); end
    // R2, R7: RESET falls, halt clears after the synchroniser delay
    tag = "R7";
    cyc(0, 0, 0, 0);
    for (int i = 0; i < SYNC + 1; i++) cyc(0, 0, 0, 0);
    @(negedge clk);
    n_checks++;
    if (halt_mode !== 1'b0) begin n_fail++; $display("FAIL R2 halt after fall actual=%0b expected=0", halt_mode); end
    // R9: rate over 40 running cycles
    tag = "R9";
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    ns = 0; nc = 0;
    for (int i = 0; i < 40; i++) begin cyc(0, 0, 0, 0); ns += sys_clk_en; nc += cpu_clk_en; end
    n_checks++;
    if (nc * 2 != ns || ns != 40) begin n_fail++; $display("FAIL R9 ratio actual=%0d/%0d expected=20/40", nc, ns); end
    // R5, R10: halt entry and phase hold
    tag = "R5";
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0);
    // R6: strobe and release together keep halt set, then release alone
    tag = "R6";
    cyc(0, 1, 1, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    tag = "R10";
    cyc(0, 0, 1, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0);
    // R7: fall of RESET exits halt, beating a halt strobe
    tag = "R7";
    cyc(0, 1, 0, 0); cyc(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);
    // R3, R4: stop entry, release ignored, RESET recovers
    tag = "R3";
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    tag = "R4";
    cyc(0, 0, 1, 0); cyc(0, 1, 0, 0); cyc(0, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
    @(negedge clk);
    n_checks++;
    if (stop_mode !== 1'b1 || osc_run !== 1'b0) begin
      n_fail++; $display("FAIL R4 stop held actual=%0b%0b expected=10", stop_mode, osc_run);
    end
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0);
    // mixed stimulus
    tag = "R10";
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      bit p;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      p = reset_pin;
      if (lf[7:2] == 6'd5) p = !p;
      cyc(lf[11:4] == 8'h3C, lf[3:1] == 3'd2, lf[9:8] == 2'd1, p);
    end
    cyc(0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule